// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-driven master for extended (Clause 45) management transactions on an MDIO bus. A host programs two registers. One holds the 16-bit target register address. The other holds a command word with the port address, the device address, a three-bit operation code and, for writes, the 16-bit payload. Writing the command word starts the sequencer. It sends an address frame and then a write or read frame, and it generates the MDC clock itself.

The host polls the busy flag in the command register until it clears. After a read, a valid flag is set and the returned value sits in the low half of the same register. The serial data pin is split into an output, an output enable and an input, so a pad cell outside the block can form the bidirectional line.

Top module: `mdio45_ctrl`

## Requirements
- R1: After reset, the command register (offset 0x0) and the address register (offset 0x8) read as zero, MDC is low and the output enable is low.
- R2: A write to offset 0x8 stores bits 15:0 of the write data as the target register address. The register reads back in bits 15:0, and bits 31:16 read as zero.
- R3: The command word holds the payload in bits 15:0, the port address in bits 20:16, the device address in bits 25:21 and the opcode in bits 28:26. Opcode 3'b101 selects a write and 3'b111 selects a read. An accepted command with one of these two opcodes makes busy (bit 30) read 1 from the next clock cycle, and the written fields read back.
- R4: The first frame is 32 ones, then start 00, opcode 00, the five port-address bits, the five device-address bits, turnaround 10 and the 16 address bits, all MSB first.
- R5: For a write, the second frame is 32 ones, then 00, 01, port address, device address, 10 and the payload, with the output enabled for all 64 bits.
- R6: For a read, the second frame drives 32 ones, 00, 11, port address and device address. The output enable is low for the last 18 bits (turnaround and data). The 16 data bits are sampled on rising MDC edges MSB first. At completion they appear in bits 15:0, with bit 29 (read valid) set.
- R7: Busy stays 1 through both frames and clears after the final falling MDC edge. Exactly 128 rising MDC edges occur per command.
- R8: A command whose opcode is neither 3'b101 nor 3'b111 starts no bus activity: busy stays 0 and MDC stays low. Its fields are still stored and read back.
- R9: While busy is 1, writes to either register are ignored. They change neither the frames in progress nor the values that read back afterwards, and they start no further access.
- R10: An accepted command write clears read valid (bit 29).
- R11: MDC is low while idle. During an access, each MDC high and low phase lasts CLK_DIV clock cycles. The data output and its enable change only at falling MDC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Byte offset for register read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data output |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data input |

## Verification
A corrupted bit counter or sequencer state shows up at the MDC pins within a single frame. It appears as a wrong number of rising edges per command, as a misplaced release of the output enable, or as a busy flag that clears early or never clears. A stale field register shows up in the captured address or data frame on the same command. A read-capture fault is seen once the host reads the command register after busy falls, and it shows as wrong data or a missing valid flag. An acceptance fault is seen one cycle after the write, in the busy flag, or on the next idle readback of the register fields.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

   localparam int unsigned CMD_W      = 32;
   localparam int unsigned FRAME_CORE = 32;

   localparam int unsigned F_PRT_LO   = 16;
   localparam int unsigned F_DEV_LO   = 21;
   localparam int unsigned F_OP_LO    = 26;
   localparam int unsigned F_VALID    = 29;
   localparam int unsigned F_BUSY     = 30;

   localparam logic [2:0] OPC_WRITE = 3'b101;
   localparam logic [2:0] OPC_READ  = 3'b111;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_ADDR   = 2'd2,
      SQ_DATA   = 2'd3
   } seq_state_e;

   // Frame body after the preamble: start, opcode, port, device, turnaround, payload
   function automatic logic [FRAME_CORE-1:0] frame_body(
      input logic [1:0]  op2,
      input logic [4:0]  prt,
      input logic [4:0]  dev,
      input logic [15:0] val
   );
      return {2'b00, op2, prt, dev, 2'b10, val};
   endfunction

   function automatic logic is_known_op(input logic [2:0] op);
      return (op == OPC_WRITE) || (op == OPC_READ);
   endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);

   localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

   logic [CNT_W-1:0] div_cnt;
   logic             mdc_q;
   logic             at_last;

   assign at_last   = run && (div_cnt == CNT_LAST);
   assign rise_tick = at_last && !mdc_q;
   assign fall_tick = at_last &&  mdc_q;
   assign mdc       = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         mdc_q   <= 1'b0;
      end else if (!run) begin
         div_cnt <= '0;
         mdc_q   <= 1'b0;
      end else if (at_last) begin
         div_cnt <= '0;
         mdc_q   <= ~mdc_q;
      end else begin
         div_cnt <= div_cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/mdio45_shifter.sv
module mdio45_shifter #(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] body,
   input  logic        is_rd,
   input  logic        rise_tick,
   input  logic        fall_tick,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        done,
   output logic [15:0] rd_word
);

   localparam int unsigned FRAME_W = PRE_LEN + mdio45_pkg::FRAME_CORE;
   localparam int unsigned CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] IDX_LAST  = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] IDX_TA_HI = CNT_W'(18);
   localparam logic [CNT_W-1:0] IDX_DATA  = CNT_W'(16);

   logic [FRAME_W-1:0] full_frame;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   bit_idx;
   logic               active;
   logic               rd_q;
   logic [15:0]        cap_q;

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign full_frame = {{PRE_LEN{1'b1}}, body};
      end else begin : g_nopre
         assign full_frame = body;
      end
   endgenerate

   assign done    = active && fall_tick && (bit_idx == '0);
   assign mdio_o  = active ? sr[FRAME_W-1] : 1'b1;
   assign mdio_oe = active && !(rd_q && (bit_idx < IDX_TA_HI));
   assign rd_word = cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         bit_idx <= '0;
         active  <= 1'b0;
         rd_q    <= 1'b0;
         cap_q   <= '0;
      end else begin
         if (active && rise_tick && rd_q && (bit_idx < IDX_DATA)) begin
            cap_q <= {cap_q[14:0], mdio_i};
         end
         if (load) begin
            sr      <= full_frame;
            bit_idx <= IDX_LAST;
            active  <= 1'b1;
            rd_q    <= is_rd;
         end else if (active && fall_tick) begin
            if (bit_idx == '0) begin
               active <= 1'b0;
               rd_q   <= 1'b0;
            end else begin
               bit_idx <= bit_idx - CNT_W'(1);
               sr      <= {sr[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs #(
   parameter int unsigned      AW       = 4,
   parameter logic [AW-1:0]    MGMT_OFF = '0,
   parameter logic [AW-1:0]    ADDR_OFF = AW'(8)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          busy,
   input  logic          rd_done,
   input  logic [15:0]   rd_word,
   output logic          start,
   output logic          cmd_rd,
   output logic [4:0]    cmd_prt,
   output logic [4:0]    cmd_dev,
   output logic [15:0]   cmd_data,
   output logic [15:0]   tgt_addr,
   output logic          rd_valid
);
   import mdio45_pkg::*;

   logic       accept;
   logic       hit_mgmt;
   logic       hit_addr;
   logic [2:0] op_q;
   logic [2:0] op_in;

   assign hit_mgmt = (reg_addr == MGMT_OFF);
   assign hit_addr = (reg_addr == ADDR_OFF);
   assign accept   = reg_wr && !busy;
   assign op_in    = reg_wdata[F_OP_LO +: 3];
   assign start    = accept && hit_mgmt && is_known_op(op_in);
   assign cmd_rd   = (op_q == OPC_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= '0;
         cmd_prt  <= '0;
         cmd_dev  <= '0;
         cmd_data <= '0;
         tgt_addr <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (accept && hit_mgmt) begin
            op_q     <= op_in;
            cmd_prt  <= reg_wdata[F_PRT_LO +: 5];
            cmd_dev  <= reg_wdata[F_DEV_LO +: 5];
            cmd_data <= reg_wdata[15:0];
            rd_valid <= 1'b0;
         end
         if (accept && hit_addr) begin
            tgt_addr <= reg_wdata[15:0];
         end
         if (rd_done) begin
            cmd_data <= rd_word;
            rd_valid <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_mgmt) begin
         reg_rdata[15:0]            = cmd_data;
         reg_rdata[F_PRT_LO +: 5]   = cmd_prt;
         reg_rdata[F_DEV_LO +: 5]   = cmd_dev;
         reg_rdata[F_OP_LO +: 3]    = op_q;
         reg_rdata[F_VALID]         = rd_valid;
         reg_rdata[F_BUSY]          = busy;
      end else if (hit_addr) begin
         reg_rdata[15:0] = tgt_addr;
      end
   end

endmodule

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl #(
   parameter int unsigned   CLK_DIV  = 4,
   parameter int unsigned   PRE_LEN  = 32,
   parameter int unsigned   AW       = 4,
   parameter logic [AW-1:0] MGMT_OFF = '0,
   parameter logic [AW-1:0] ADDR_OFF = AW'(8)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mdc,
   output logic          mdio_o,
   output logic          mdio_oe,
   input  logic          mdio_i
);
   import mdio45_pkg::*;

   generate
      if (CLK_DIV < 2) begin : g_chk_div
         $error("mdio45_ctrl: CLK_DIV must be at least 2");
      end
      if (MGMT_OFF == ADDR_OFF) begin : g_chk_off
         $error("mdio45_ctrl: register offsets must differ");
      end
      if (AW < 2) begin : g_chk_aw
         $error("mdio45_ctrl: AW too small");
      end
   endgenerate

   seq_state_e  seq_q;
   logic        seq_busy;
   logic        clk_run;
   logic        rise_tick;
   logic        fall_tick;
   logic        frm_done;
   logic        frm_load;
   logic        frm_rd;
   logic [31:0] frm_body;
   logic [15:0] rd_word;
   logic        rd_done;
   logic        start;
   logic        cmd_rd;
   logic [4:0]  cmd_prt;
   logic [4:0]  cmd_dev;
   logic [15:0] cmd_data;
   logic [15:0] regs_addr;
   logic        regs_valid;

   assign seq_busy = (seq_q != SQ_IDLE);
   assign clk_run  = (seq_q == SQ_ADDR) || (seq_q == SQ_DATA);
   assign frm_load = (seq_q == SQ_LAUNCH) || ((seq_q == SQ_ADDR) && frm_done);
   assign frm_rd   = (seq_q == SQ_ADDR) && cmd_rd;
   assign rd_done  = (seq_q == SQ_DATA) && frm_done && cmd_rd;

   always_comb begin
      if (seq_q == SQ_LAUNCH) begin
         frm_body = frame_body(2'b00, cmd_prt, cmd_dev, regs_addr);
      end else if (cmd_rd) begin
         frm_body = frame_body(2'b11, cmd_prt, cmd_dev, 16'h0000);
      end else begin
         frm_body = frame_body(2'b01, cmd_prt, cmd_dev, cmd_data);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= SQ_IDLE;
      end else begin
         case (seq_q)
            SQ_IDLE:   if (start)    seq_q <= SQ_LAUNCH;
            SQ_LAUNCH:               seq_q <= SQ_ADDR;
            SQ_ADDR:   if (frm_done) seq_q <= SQ_DATA;
            SQ_DATA:   if (frm_done) seq_q <= SQ_IDLE;
            default:                 seq_q <= SQ_IDLE;
         endcase
      end
   end

   mdio45_regs #(
      .AW       (AW),
      .MGMT_OFF (MGMT_OFF),
      .ADDR_OFF (ADDR_OFF)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (seq_busy),
      .rd_done   (rd_done),
      .rd_word   (rd_word),
      .start     (start),
      .cmd_rd    (cmd_rd),
      .cmd_prt   (cmd_prt),
      .cmd_dev   (cmd_dev),
      .cmd_data  (cmd_data),
      .tgt_addr  (regs_addr),
      .rd_valid  (regs_valid)
   );

   mdio45_clkgen #(
      .CLK_DIV (CLK_DIV)
   ) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (clk_run),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio45_shifter #(
      .PRE_LEN (PRE_LEN)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frm_load),
      .body      (frm_body),
      .is_rd     (frm_rd),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .done      (frm_done),
      .rd_word   (rd_word)
   );

endmodule

// File: rtl/mdio45_ctrl_chk.sv
module mdio45_ctrl_chk #(
   parameter int unsigned   AW       = 4,
   parameter logic [AW-1:0] MGMT_OFF = '0,
   parameter logic [AW-1:0] ADDR_OFF = AW'(8)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [AW-1:0] reg_addr,
   input logic [31:0]   reg_wdata,
   input logic          busy,
   input logic          valid,
   input logic [15:0]   addr_q,
   input logic          mdc,
   input logic          mdio_o,
   input logic          mdio_oe
);

   logic wr_mgmt;
   logic op_ok;

   assign wr_mgmt = reg_wr && (reg_addr == MGMT_OFF) && !busy;
   assign op_ok   = (reg_wdata[28:26] == 3'b101) || (reg_wdata[28:26] == 3'b111);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe)) else $error("idle bus not quiet"); // R11

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mgmt && op_ok) |=> busy) else $error("command did not start"); // R3

   AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mgmt && !op_ok) |=> !busy) else $error("unknown opcode started access"); // R8

   AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && (reg_addr == ADDR_OFF)) |=> $stable(addr_q)) else $error("address changed while busy"); // R9

   AST_VALID_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !valid) else $error("read valid during access"); // R10

   AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))) else $error("data moved at MDC rise"); // R11

endmodule

bind mdio45_ctrl mdio45_ctrl_chk #(
   .AW       (AW),
   .MGMT_OFF (MGMT_OFF),
   .ADDR_OFF (ADDR_OFF)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .busy      (seq_busy),
   .valid     (regs_valid),
   .addr_q    (regs_addr),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe)
);

// File: tb/test_mdio45_ctrl.sv
`timescale 1ns/1ps
module test_mdio45_ctrl;

   localparam int DIV = 4;
   localparam int TCK = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;
   int ntot  = 0;
   int base  = 0;
   bit fin   = 0;
   logic       cap_b [0:1023];
   logic       cap_e [0:1023];
   logic [15:0] phy_val = 16'h0000;

   always #(TCK/2) clk = ~clk;

   mdio45_ctrl #(.CLK_DIV(DIV)) i_mdio45_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_i    (mdio_i)
   );

   // bus monitor: record each bit at rising MDC
   always @(posedge mdc) begin
      #1;
      if (ntot < 1024) begin
         cap_b[ntot] = mdio_o;
         cap_e[ntot] = mdio_oe;
      end
      ntot = ntot + 1;
   end

   // responder: present read data after falling MDC
   always @(negedge mdc) begin
      int k;
      #1;
      k = ntot - base;
      if (k >= 112 && k < 128) mdio_i = phy_val[127-k];
      else                     mdio_i = 1'b1;
   end

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] v;
      int n;
      n = 0;
      v = 32'hFFFF_FFFF;
      while (n < 5000 && v[30]) begin
         rd(4'h0, v);
         n++;
      end
      check(req, 128'(v[30]), 128'(0));
   endtask

   function automatic logic [31:0] mk_cmd(input logic [2:0] op, input logic [4:0] dev,
                                          input logic [4:0] prt, input logic [15:0] d);
      return {3'b000, op, dev, prt, d};
   endfunction

   function automatic logic [127:0] mk_frames(input logic [4:0] prt, input logic [4:0] dev,
                                              input logic [15:0] a, input logic [1:0] op2,
                                              input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b00, 2'b00, prt, dev, 2'b10, a,
              32'hFFFF_FFFF, 2'b00, op2,   prt, dev, 2'b10, d};
   endfunction

   task automatic get_cap(output logic [127:0] v, output logic [127:0] e);
      for (int k = 0; k < 128; k++) begin
         v[127-k] = cap_b[base+k];
         e[127-k] = cap_e[base+k];
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      rd(4'h0, v);
      check("R1 command reg", 128'(v), 128'(0));
      rd(4'h8, v);
      check("R1 address reg", 128'(v), 128'(0));
      check("R1 mdc/oe", 128'({mdc, mdio_oe}), 128'(0));
   endtask

   task automatic t_addr_reg();
      logic [31:0] v;
      wr(4'h8, 32'hABCD_1234);
      rd(4'h8, v);
      check("R2 address readback", 128'(v), 128'(32'h0000_1234));
   endtask

   task automatic t_write_access();
      logic [31:0]  v;
      logic [127:0] cv, ce;
      int n;
      base = ntot;
      wr(4'h0, mk_cmd(3'b101, 5'h03, 5'h11, 16'hA55A));
      rd(4'h0, v);
      check("R3 busy after command", 128'(v[30]), 128'(1));
      check("R3 field readback", 128'(v[28:0]), 128'(mk_cmd(3'b101, 5'h03, 5'h11, 16'hA55A)));
      @(posedge mdc);
      n = 0;
      do begin @(posedge clk); #1; n++; end while (mdc && n < 100);
      check("R11 MDC high phase", 128'(n), 128'(DIV));
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!mdc && n < 100);
      check("R11 MDC low phase", 128'(n), 128'(DIV));
      wait (ntot - base >= 70);
      rd(4'h0, v);
      check("R7 busy between frames", 128'(v[30]), 128'(1));
      wait_idle("R7 busy clears");
      check("R7 rising edge count", 128'(ntot - base), 128'(128));
      get_cap(cv, ce);
      check("R4 address frame", {64'h0, cv[127:64]},
            {64'h0, mk_frames(5'h11, 5'h03, 16'h1234, 2'b01, 16'hA55A) >> 64});
      check("R5 write frame", {64'h0, cv[63:0]},
            {64'h0, mk_frames(5'h11, 5'h03, 16'h1234, 2'b01, 16'hA55A) & {64'h0, {64{1'b1}}}});
      check("R5 output enable", ce, {128{1'b1}});
   endtask

   task automatic t_read_access();
      logic [31:0]  v;
      logic [127:0] cv, ce, m;
      wr(4'h8, 32'h0000_0042);
      phy_val = 16'hC3A5;
      base = ntot;
      wr(4'h0, mk_cmd(3'b111, 5'h1F, 5'h05, 16'h0000));
      wait_idle("R7 read completes");
      get_cap(cv, ce);
      m = {{110{1'b1}}, 18'h0};
      check("R4 address frame (read)", cv & m & {{64{1'b1}}, 64'h0},
            mk_frames(5'h05, 5'h1F, 16'h0042, 2'b11, 16'h0) & m & {{64{1'b1}}, 64'h0});
      check("R6 read frame driven bits", cv & m,
            mk_frames(5'h05, 5'h1F, 16'h0042, 2'b11, 16'h0) & m);
      check("R6 output release", ce, m);
      rd(4'h0, v);
      check("R6 read data", 128'(v[15:0]), 128'(16'hC3A5));
      check("R6 read valid", 128'(v[30:29]), 128'(2'b01));
   endtask

   task automatic t_valid_clear();
      logic [31:0] v;
      base = ntot;
      wr(4'h0, mk_cmd(3'b101, 5'h00, 5'h01, 16'h0F0F));
      rd(4'h0, v);
      check("R10 valid cleared by command", 128'(v[30:29]), 128'(2'b10));
      wait_idle("R7 write completes");
      rd(4'h0, v);
      check("R10 valid stays clear after write", 128'(v[29]), 128'(0));
   endtask

   task automatic t_busy_ignore();
      logic [31:0]  v;
      logic [127:0] cv, ce;
      wr(4'h8, 32'h0000_0777);
      base = ntot;
      wr(4'h0, mk_cmd(3'b101, 5'h02, 5'h09, 16'h1357));
      repeat (10) @(negedge clk);
      wr(4'h0, mk_cmd(3'b111, 5'h1C, 5'h1A, 16'hFFFF));
      wr(4'h8, 32'h0000_BEEF);
      wait_idle("R9 access completes");
      repeat (200) @(negedge clk);
      check("R9 no extra access", 128'(ntot - base), 128'(128));
      get_cap(cv, ce);
      check("R9 frames unchanged", cv, mk_frames(5'h09, 5'h02, 16'h0777, 2'b01, 16'h1357));
      rd(4'h8, v);
      check("R9 address kept", 128'(v), 128'(32'h0000_0777));
      rd(4'h0, v);
      check("R9 command kept", 128'(v), 128'(mk_cmd(3'b101, 5'h02, 5'h09, 16'h1357)));
   endtask

   task automatic t_bad_op(input logic [2:0] op);
      logic [31:0] v;
      base = ntot;
      wr(4'h0, mk_cmd(op, 5'h04, 5'h06, 16'h2468));
      rd(4'h0, v);
      check("R8 no busy", 128'(v[30]), 128'(0));
      check("R8 fields stored", 128'(v[28:0]), 128'(mk_cmd(op, 5'h04, 5'h06, 16'h2468)));
      repeat (100) @(negedge clk);
      check("R8 no MDC edges", 128'(ntot - base), 128'(0));
      check("R8 MDC low", 128'(mdc), 128'(0));
   endtask

   initial begin
      t_reset();
      t_addr_reg();
      t_write_access();
      t_read_access();
      t_valid_clear();
      t_busy_ignore();
      t_bad_op(3'b010);
      t_bad_op(3'b100);
      fin = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(TCK * 150000);
      if (!fin) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule